// File: doc/BRIEF.md
# Three-Channel Serial Register Front End

This block is the register-level front end of three byte-oriented serial channels. A simple bus slave port presents a sparse 64-byte offset space. Each channel has a 16-bit control register, an 8-bit interrupt-mode register, a transmit buffer, a receive buffer and a status register. Channel 2 also has an 8-bit timer-setting register. The block decodes every access by offset and byte size and checks read-only bits. An access that breaks a rule raises an error pulse and changes no register.

On the channel side, the block takes a received byte with a valid strobe, latches it and raises that channel's receive-ready flag. A legal byte write to a transmit buffer presents the byte on the channel's transmit output with a one-cycle send pulse. Baud generation, bit serialisation and interrupt routing are left to the blocks around it.

Top module: `tri_uart_regs`

## Requirements
- R1: Channel n (0..2) has control at offset 0x10·n+0x0, interrupt mode at +0x4, transmit buffer at +0x8, receive buffer at +0x9 and status at +0xC. Channel 2 alone has a timer register at offset 0x2D. After reset, every register reads as zero.
- R2: Control registers are 16 bits wide and accept only 2-byte reads and writes (`bus_size`=2). Read data is little-endian, with the low byte in bits 7:0.
- R3: The interrupt-mode, transmit-buffer, receive-buffer and timer registers accept only 1-byte accesses (`bus_size`=1). Write data is taken from `bus_wdata[7:0]`, and read data is returned zero-extended.
- R4: A status register reads as 1 byte on any channel. Channels 0 and 1 also allow a 2-byte read. Channel 2 does not.
- R5: Status bit 4 (value 0x0010) is receive-ready. It sets when `rx_valid[n]` loads `rx_data[8n+7:8n]` into the receive buffer, and it clears on a legal read of that buffer. Each load pulses `rx_event[n]` in the next cycle.
- R6: A write to the channel 2 control register with any bit of 0x0C04 set is illegal.
- R7: A write to an interrupt-mode register is illegal if it sets any bit of 0xCA on channel 2, or any bit of 0x4A on channels 0 and 1.
- R8: Writes to receive-buffer or status registers are illegal. Any offset outside the map is illegal for reads and writes. Raising `bus_rd` and `bus_wr` together is illegal.
- R9: A legal transmit-buffer write stores the byte and shows it on `tx_data[8n+7:8n]`. It also raises `tx_send[n]` for exactly one cycle.
- R10: An illegal access raises `bus_err` in the next cycle and leaves all register state unchanged.
- R11: A byte that arrives while receive-ready is set overwrites the buffer, and the flag stays set. A receive-buffer read in the same cycle as an arrival returns the old byte and leaves the flag set.
- R12: `bus_rdata` is registered. It holds the read value in the cycle after a legal read, and it is zero after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 6 | Register offset |
| bus_size | input | 2 | Access size in bytes (1 or 2) |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| bus_err | output | 1 | Illegal-access pulse |
| rx_data | input | 24 | Received byte per channel |
| rx_valid | input | 3 | Received-byte strobe per channel |
| tx_data | output | 24 | Transmit byte per channel |
| tx_send | output | 3 | Send pulse per channel |
| rx_event | output | 3 | Receive-event pulse per channel |

## Verification
A wrong legality decision shows up one cycle after the access. It appears as a missing or spurious `bus_err`, and the bench also sees the register state change or fail to change on a later readback. A receive-ready flag or buffer that is wrong stays hidden until the next status or receive-buffer read, so the bench interleaves such reads with arrivals and collisions. A transmit error appears at once as a wrong `tx_send` pulse or a wrong `tx_data` byte.

// File: rtl/tri_uart_regs.sv
module tri_uart_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  bus_addr,
  input  logic [1:0]  bus_size,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        bus_err,
  input  logic [23:0] rx_data,
  input  logic [2:0]  rx_valid,
  output logic [23:0] tx_data,
  output logic [2:0]  tx_send,
  output logic [2:0]  rx_event
);
  logic [15:0] ctrl [3];
  logic [7:0]  imode [3];
  logic [7:0]  txb [3];
  logic [7:0]  rxb [3];
  logic [2:0]  rdy;
  logic [7:0]  tim;
  logic [15:0] rd_val;

  wire [1:0] ch  = bus_addr[5:4];
  wire [3:0] off = bus_addr[3:0];
  wire in_ch  = ch != 2'd3;
  wire is_ctl = in_ch && off == 4'h0;
  wire is_imd = in_ch && off == 4'h4;
  wire is_txb = in_ch && off == 4'h8;
  wire is_rxb = in_ch && off == 4'h9;
  wire is_sts = in_ch && off == 4'hC;
  wire is_tim = bus_addr == 6'h2D;
  wire sz1 = bus_size == 2'd1;
  wire sz2 = bus_size == 2'd2;
  wire [7:0] imd_ro = (ch == 2'd2) ? 8'hCA : 8'h4A;
  wire ctl_ro_hit = (ch == 2'd2) && ((bus_wdata & 16'h0C04) != 16'h0);

  wire rd_ok = (is_ctl && sz2) || ((is_imd || is_txb || is_rxb || is_tim) && sz1)
             || (is_sts && (sz1 || (sz2 && ch != 2'd2)));
  wire wr_ok = (is_ctl && sz2 && !ctl_ro_hit)
             || (is_imd && sz1 && ((bus_wdata[7:0] & imd_ro) == 8'h0))
             || ((is_txb || is_tim) && sz1);
  wire legal_rd = bus_rd && !bus_wr && rd_ok;
  wire legal_wr = bus_wr && !bus_rd && wr_ok;
  wire illegal  = (bus_rd || bus_wr) && !legal_rd && !legal_wr;

  always_comb begin
    rd_val = '0;
    for (int c = 0; c < 3; c++)
      if (ch == 2'(c))
        case (off)
          4'h0: rd_val = ctrl[c];
          4'h4: rd_val = {8'h0, imode[c]};
          4'h8: rd_val = {8'h0, txb[c]};
          4'h9: rd_val = {8'h0, rxb[c]};
          4'hC: rd_val = {11'h0, rdy[c], 4'h0};
          default: rd_val = '0;
        endcase
    if (is_tim) rd_val = {8'h0, tim};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < 3; c++) begin
        ctrl[c]  <= '0;
        imode[c] <= '0;
        txb[c]   <= '0;
        rxb[c]   <= '0;
      end
      rdy       <= '0;
      tim       <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
      tx_send   <= '0;
      rx_event  <= '0;
    end else begin
      bus_rdata <= legal_rd ? rd_val : 16'h0;
      bus_err   <= illegal;
      rx_event  <= rx_valid;
      tx_send   <= '0;
      for (int c = 0; c < 3; c++) begin
        if (rx_valid[c]) begin
          rxb[c] <= rx_data[8*c +: 8];
          rdy[c] <= 1'b1;
        end else if (legal_rd && is_rxb && ch == 2'(c)) begin
          rdy[c] <= 1'b0;
        end
        if (legal_wr && ch == 2'(c)) begin
          if (is_ctl) ctrl[c]  <= bus_wdata;
          if (is_imd) imode[c] <= bus_wdata[7:0];
          if (is_txb) begin
            txb[c]     <= bus_wdata[7:0];
            tx_send[c] <= 1'b1;
          end
        end
      end
      if (legal_wr && is_tim) tim <= bus_wdata[7:0];
    end
  end

  assign tx_data = {txb[2], txb[1], txb[0]};
endmodule

module tri_uart_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic        bus_err,
  input logic [15:0] bus_rdata,
  input logic [2:0]  tx_send,
  input logic [2:0]  rx_valid,
  input logic [2:0]  rx_event,
  input logic [2:0]  rdy
);
  assert_one_send_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tx_send));
  assert_err_no_send_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> tx_send == 3'b000);
  assert_both_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_wr) |=> bus_err);
  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd && !bus_wr) |=> (bus_rdata == 16'h0 && !bus_err));
  assert_rx_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> (rx_event == $past(rx_valid)));
  assert_rdy_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|rx_valid) |=> ((rdy & $past(rx_valid)) == $past(rx_valid)));
endmodule

bind tri_uart_regs tri_uart_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_err(bus_err), .bus_rdata(bus_rdata), .tx_send(tx_send),
  .rx_valid(rx_valid), .rx_event(rx_event), .rdy(rdy)
);

// File: tb/tri_uart_regs_test.sv
`timescale 1ns/1ps
module tri_uart_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  bus_addr = 0;
  logic [1:0]  bus_size = 0;
  logic        bus_rd = 0, bus_wr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic        bus_err;
  logic [23:0] rx_data = 0;
  logic [2:0]  rx_valid = 0;
  logic [23:0] tx_data;
  logic [2:0]  tx_send, rx_event;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [15:0] m_ctrl [3];
  logic [7:0]  m_imd [3], m_txb [3], m_rxb [3];
  logic [2:0]  m_rdy;
  logic [7:0]  m_tim;

  tri_uart_regs uut (.*);

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic bit b_rd_ok(input [5:0] a, input [1:0] sz);
    logic [1:0] c = a[5:4];
    if (a == 6'h2D) return sz == 1;
    if (c == 3) return 0;
    case (a[3:0])
      4'h0: return sz == 2;
      4'h4, 4'h8, 4'h9: return sz == 1;
      4'hC: return sz == 1 || (sz == 2 && c != 2);
      default: return 0;
    endcase
  endfunction

  function automatic bit b_wr_ok(input [5:0] a, input [1:0] sz, input [15:0] wd);
    logic [1:0] c = a[5:4];
    if (a == 6'h2D) return sz == 1;
    if (c == 3) return 0;
    case (a[3:0])
      4'h0: return sz == 2 && !(c == 2 && (wd & 16'h0C04) != 0);
      4'h4: return sz == 1 && (wd[7:0] & (c == 2 ? 8'hCA : 8'h4A)) == 0;
      4'h8: return sz == 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [15:0] b_read(input [5:0] a);
    int c = a[5:4];
    if (a == 6'h2D) return {8'h0, m_tim};
    case (a[3:0])
      4'h0: return m_ctrl[c];
      4'h4: return {8'h0, m_imd[c]};
      4'h8: return {8'h0, m_txb[c]};
      4'h9: return {8'h0, m_rxb[c]};
      default: return {11'h0, m_rdy[c], 4'h0};
    endcase
  endfunction

  task automatic cyc(input bit rd, input bit wr, input [5:0] a, input [1:0] sz,
                     input [15:0] wd, input [2:0] rv, input [23:0] rdat,
                     input string req);
    bit lr = rd && !wr && b_rd_ok(a, sz);
    bit lw = wr && !rd && b_wr_ok(a, sz, wd);
    logic [15:0] e_rd = lr ? b_read(a) : 16'h0;
    bit e_err = (rd || wr) && !lr && !lw;
    logic [2:0] e_send = (lw && a[3:0] == 4'h8 && a != 6'h2D) ? 3'(1 << a[5:4]) : 3'b0;
    int c = a[5:4];
    if (lw) begin
      if (a == 6'h2D) m_tim = wd[7:0];
      else case (a[3:0])
        4'h0: m_ctrl[c] = wd;
        4'h4: m_imd[c] = wd[7:0];
        default: m_txb[c] = wd[7:0];
      endcase
    end
    if (lr && a[3:0] == 4'h9) m_rdy[c] = 0;
    for (int k = 0; k < 3; k++)
      if (rv[k]) begin m_rxb[k] = rdat[8*k +: 8]; m_rdy[k] = 1; end
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_size = sz; bus_wdata = wd;
    rx_valid = rv; rx_data = rdat;
    @(negedge clk);
    bus_rd = 0; bus_wr = 0; rx_valid = 0;
    chk(bus_rdata == e_rd, req, "rdata", bus_rdata, e_rd);
    chk(bus_err == e_err, req, "err", bus_err, e_err);
    chk(tx_send == e_send, req, "tx_send", tx_send, e_send);
    chk(rx_event == rv, req, "rx_event", rx_event, rv);
    chk(tx_data == {m_txb[2], m_txb[1], m_txb[0]}, req, "tx_data", tx_data,
        {m_txb[2], m_txb[1], m_txb[0]});
  endtask

  task automatic rd_(input [5:0] a, input [1:0] sz, input string req);
    cyc(1, 0, a, sz, 16'h0, 3'b0, 24'h0, req);
  endtask
  task automatic wr_(input [5:0] a, input [1:0] sz, input [15:0] wd, input string req);
    cyc(0, 1, a, sz, wd, 3'b0, 24'h0, req);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      m_ctrl[k] = 0; m_imd[k] = 0; m_txb[k] = 0; m_rxb[k] = 0;
    end
    m_rdy = 0; m_tim = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bus_rdata == 0 && !bus_err && tx_send == 0, "R1", "reset outputs", bus_rdata, 0);
    for (int k = 0; k < 3; k++) begin
      rd_(6'(16*k), 2, "R1");
      rd_(6'(16*k + 4), 1, "R1");
      rd_(6'(16*k + 12), 1, "R1");
    end
    rd_(6'h2D, 1, "R1");
    wr_(6'h00, 2, 16'hA55A, "R2");
    rd_(6'h00, 2, "R2");
    rd_(6'h00, 1, "R2");
    wr_(6'h10, 1, 16'h0011, "R2");
    wr_(6'h14, 2, 16'h0001, "R3");
    wr_(6'h2D, 1, 16'hFF3C, "R3");
    rd_(6'h2D, 1, "R3");
    rd_(6'h08, 2, "R3");
    wr_(6'h20, 2, 16'h0004, "R6");
    wr_(6'h20, 2, 16'h0800, "R6");
    wr_(6'h20, 2, 16'hF3FB, "R6");
    rd_(6'h20, 2, "R6");
    wr_(6'h04, 1, 16'h0002, "R7");
    wr_(6'h04, 1, 16'h0080, "R7");
    wr_(6'h24, 1, 16'h0080, "R7");
    wr_(6'h24, 1, 16'h0035, "R7");
    rd_(6'h04, 1, "R7");
    rd_(6'h24, 1, "R7");
    wr_(6'h18, 1, 16'h7741, "R9");
    wr_(6'h28, 1, 16'h0042, "R9");
    rd_(6'h18, 1, "R9");
    cyc(0, 0, 6'h0, 0, 0, 3'b001, 24'h0000C3, "R5");
    rd_(6'h0C, 2, "R4");
    rd_(6'h0C, 1, "R5");
    rd_(6'h09, 1, "R5");
    rd_(6'h0C, 1, "R5");
    cyc(0, 0, 6'h0, 0, 0, 3'b100, 24'h5E0000, "R5");
    rd_(6'h2C, 2, "R4");
    rd_(6'h2C, 1, "R4");
    cyc(0, 0, 6'h0, 0, 0, 3'b100, 24'h610000, "R11");
    cyc(1, 0, 6'h29, 1, 0, 3'b100, 24'h7A0000, "R11");
    rd_(6'h2C, 1, "R11");
    rd_(6'h29, 1, "R11");
    rd_(6'h2C, 1, "R11");
    wr_(6'h09, 1, 16'h0055, "R8");
    wr_(6'h1C, 1, 16'h0010, "R8");
    rd_(6'h30, 1, "R8");
    rd_(6'h01, 1, "R8");
    cyc(1, 1, 6'h08, 1, 16'h0033, 3'b0, 24'h0, "R8");
    rd_(6'h08, 1, "R10");
    for (int i = 0; i < 3000; i++) begin
      int c = $urandom_range(0, 2);
      logic [5:0] a;
      logic [15:0] wd = 16'($urandom);
      int pick = $urandom_range(0, 9);
      bit rd, wr;
      if (pick < 6) a = 6'(16*c) + 6'(pick == 0 ? 0 : pick == 1 ? 4 : pick == 2 ? 8 :
                                      pick == 3 ? 9 : 12);
      else if (pick == 6) a = 6'h2D;
      else a = 6'($urandom);
      if ($urandom_range(0, 1) == 1) wd = wd & ~16'h0CCE;
      rd = $urandom_range(0, 9) < 5;
      wr = !rd ? ($urandom_range(0, 9) < 8) : ($urandom_range(0, 19) == 0);
      cyc(rd, wr, a, 2'($urandom_range(0, 3)), wd,
          ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0, 24'($urandom), "R10");
    end
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule